// File: doc/BRIEF.md
# Queue Descriptor Cache

This block keeps a handful of queue descriptors close to the threads that manipulate packet queues. A descriptor names the first buffer of a queue, the last buffer, and the number of buffers queued. All descriptors live in a slow external memory. The cache is fully associative, and each entry holds one descriptor tagged by its queue number. Requesters send only two kinds of command: "append this buffer to queue q" and "take the oldest buffer from queue q". The cache performs the descriptor arithmetic itself and keeps the per-buffer successor links in an internal table. A requester therefore never reads or writes a descriptor.

Commands are taken one at a time. A command that hits a resident descriptor finishes after a short, parameterised lookup with no external traffic. A miss picks a free entry when one exists. Otherwise it picks the least recently used entry, writes that descriptor back and waits for the acknowledge. It then reads the wanted descriptor and applies the command to it. Several threads hammering the same queue therefore pay the external latency once and then run at cache speed. A flush input pushes every resident descriptor back to memory and empties the cache. The entry count is a parameter and is meant to match the number of threads that work on queues at once.

Top module: `qdesc_cache`

## Requirements
- R1: After reset, cmd_ready is 1 and rsp_valid and mem_req_valid are 0. Every entry is empty, so the first command misses and issues only a read request.
- R2: A command whose queue is resident raises rsp_valid with rsp_hit=1 exactly HIT_CYCLES+1 cycles after the cycle in which it was accepted (cmd_valid and cmd_ready both high). It issues no memory request.
- R3: A miss while some entry is free issues exactly one request, a read (mem_req_we=0) of the command's queue, into the lowest-numbered free entry. Let L be the number of cycles from a request cycle to the cycle in which mem_rsp_valid is high. The response then comes HIT_CYCLES+L+2 cycles after acceptance, with rsp_hit=0.
- R4: A miss with every entry full first issues a write (mem_req_we=1) carrying the victim's queue number and descriptor. Only after that write is acknowledged does it issue the read. The response comes HIT_CYCLES+2L+3 cycles after acceptance.
- R5: Every completed command makes its entry the most recently used. The victim of a full-cache miss is the resident queue whose last command is the oldest.
- R6: Each queue behaves as a FIFO of buffer numbers. For an append, rsp_buf echoes the appended buffer. For a take, rsp_buf is the oldest buffer. rsp_count is the count after the command. This state survives eviction and refetch.
- R7: A take on a queue whose count is zero returns rsp_empty=1 and rsp_count=0 and leaves the descriptor unchanged, but it still refreshes the entry's recency.
- R8: cmd_ready is high only while the block is idle. It falls in the cycle after acceptance, stays low through the response cycle, and is high again in the cycle that follows.
- R9: A flush writes back every valid entry in ascending entry order, waiting for each acknowledge, and then empties the cache. With V valid entries, cmd_ready returns N_ENTRIES+V*L+1 cycles after the flush is accepted, and the next command misses with no writeback.
- R10: When flush_req and cmd_valid are both high in an idle cycle, the flush is taken and the command is dropped: no response appears during the flush.
- R11: A descriptor on the memory port is {head, tail, count}, with head in the top PTR_W bits, tail below it and a count of PTR_W+1 bits in the low bits. An all-zero word is an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command or flush accepted |
| cmd_deq | input | 1 | 1 = take oldest buffer, 0 = append buffer |
| cmd_qid | input | QID_W | Target queue number |
| cmd_buf | input | PTR_W | Buffer to append |
| flush_req | input | 1 | Write back and invalidate all entries |
| rsp_valid | output | 1 | One-cycle command result |
| rsp_hit | output | 1 | Descriptor was resident |
| rsp_empty | output | 1 | Take found an empty queue |
| rsp_buf | output | PTR_W | Appended or removed buffer |
| rsp_count | output | PTR_W+1 | Queue length after the command |
| mem_req_valid | output | 1 | One-cycle memory request |
| mem_req_we | output | 1 | 1 = write back, 0 = read |
| mem_req_qid | output | QID_W | Descriptor address |
| mem_req_wdata | output | 2*PTR_W+PTR_W+1 | Descriptor written back |
| mem_rsp_valid | input | 1 | Memory acknowledge / read data valid |
| mem_rsp_rdata | input | 2*PTR_W+PTR_W+1 | Descriptor read |

## Verification
The bench targets the recency order. It refreshes an older entry with a take on an empty queue and then forces an eviction. A design that ignored that access, or ranked by fill order, would write back the wrong queue. A queue is evicted while it still holds buffers and is refetched later. A lost or misformatted writeback would return the wrong oldest buffer or count. A flush is offered together with a command. A design that also served the command would raise a response mid-flush, and one that skipped entries or wrote them out of order would show a wrong write-back sequence. Response cycles are compared cycle by cycle, so an extra or missing wait state in any path shows as a timing mismatch.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_APPLY,
    ST_FL_REQ,
    ST_FL_WAIT
  } qdc_state_e;

endpackage

// File: rtl/qdc_lru.sv
// Age-rank recency tracker: rank 0 is most recent, N-1 is oldest.
module qdc_lru #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid,
  output logic [IW-1:0] victim_idx
);

  logic [IW-1:0] age_q [N];
  logic [IW-1:0] age_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (IW'(i) == touch_idx)
        age_d[i] = '0;
      else if (age_q[i] < age_q[touch_idx])
        age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  // Lowest free entry wins; otherwise the oldest rank.
  always_comb begin
    victim_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (age_q[i] == IW'(N - 1)) victim_idx = IW'(i);
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i]) victim_idx = IW'(i);
  end

endmodule

// File: rtl/qdc_store.sv
// Tag, valid and descriptor storage with parallel match.
module qdc_store #(
  parameter int N      = 4,
  parameter int QID_W  = 4,
  parameter int DESC_W = 19,
  parameter int IW     = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QID_W-1:0]  look_qid,
  output logic              hit,
  output logic [IW-1:0]     hit_idx,
  output logic [N-1:0]      valid,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [QID_W-1:0]  wr_qid,
  input  logic [DESC_W-1:0] wr_desc,
  input  logic              clr_all,
  input  logic [IW-1:0]     rd_idx,
  output logic [QID_W-1:0]  rd_qid,
  output logic [DESC_W-1:0] rd_desc
);

  logic [N-1:0]      valid_q;
  logic [QID_W-1:0]  tag_q  [N];
  logic [DESC_W-1:0] desc_q [N];
  logic [N-1:0]      match;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = valid_q[g] && (tag_q[g] == look_qid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) hit_idx = IW'(i);
  end

  assign hit     = |match;
  assign valid   = valid_q;
  assign rd_qid  = tag_q[rd_idx];
  assign rd_desc = desc_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else if (clr_all)
      valid_q <= '0;
    else if (wr_en)
      valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_qid;
      desc_q[wr_idx] <= wr_desc;
    end
  end

endmodule

// File: rtl/qdc_link.sv
// Successor table: one next-buffer pointer per buffer.
module qdc_link #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [PTR_W-1:0] rd_data
);

  localparam int DEPTH = 1 << PTR_W;

  logic [PTR_W-1:0] next_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) next_q[wr_addr] <= wr_data;
  end

  assign rd_data = next_q[rd_addr];

endmodule

// File: rtl/qdesc_cache.sv
module qdesc_cache
  import qdc_pkg::*;
#(
  parameter int N_ENTRIES  = 4,
  parameter int QID_W      = 4,
  parameter int PTR_W      = 6,
  parameter int HIT_CYCLES = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_deq,
  input  logic [QID_W-1:0]           cmd_qid,
  input  logic [PTR_W-1:0]           cmd_buf,
  input  logic                       flush_req,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_empty,
  output logic [PTR_W-1:0]           rsp_buf,
  output logic [PTR_W:0]             rsp_count,
  output logic                       mem_req_valid,
  output logic                       mem_req_we,
  output logic [QID_W-1:0]           mem_req_qid,
  output logic [3*PTR_W:0]           mem_req_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [3*PTR_W:0]           mem_rsp_rdata
);

  localparam int IW     = $clog2(N_ENTRIES);
  localparam int CNT_W  = PTR_W + 1;
  localparam int DESC_W = 2 * PTR_W + CNT_W;
  localparam int HC_W   = $clog2(HIT_CYCLES + 1);

  qdc_state_e        state_q, state_d;
  logic [HC_W-1:0]   hcnt_q, hcnt_d;
  logic              deq_q, deq_d;
  logic [QID_W-1:0]  qid_q, qid_d;
  logic [PTR_W-1:0]  buf_q, buf_d;
  logic [IW-1:0]     slot_q, slot_d;
  logic              hit_q, hit_d;

  logic              st_hit, st_wr, st_clr;
  logic [IW-1:0]     st_hit_idx, victim;
  logic [N_ENTRIES-1:0] st_valid;
  logic [QID_W-1:0]  rd_qid;
  logic [DESC_W-1:0] rd_desc, wr_desc, new_desc;
  logic              last_slot;

  logic [PTR_W-1:0]  cur_head, cur_tail, link_rd;
  logic [CNT_W-1:0]  cur_cnt;
  logic [PTR_W-1:0]  nxt_head, nxt_tail;
  logic [CNT_W-1:0]  nxt_cnt;
  logic              link_we, is_empty;
  logic [PTR_W-1:0]  out_buf;

  qdc_store #(
    .N(N_ENTRIES), .QID_W(QID_W), .DESC_W(DESC_W), .IW(IW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_qid (qid_q),
    .hit      (st_hit),
    .hit_idx  (st_hit_idx),
    .valid    (st_valid),
    .wr_en    (st_wr),
    .wr_idx   (slot_q),
    .wr_qid   (qid_q),
    .wr_desc  (wr_desc),
    .clr_all  (st_clr),
    .rd_idx   (slot_q),
    .rd_qid   (rd_qid),
    .rd_desc  (rd_desc)
  );

  qdc_lru #(.N(N_ENTRIES), .IW(IW)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (state_q == ST_APPLY),
    .touch_idx  (slot_q),
    .valid      (st_valid),
    .victim_idx (victim)
  );

  qdc_link #(.PTR_W(PTR_W)) u_link (
    .clk     (clk),
    .wr_en   (link_we),
    .wr_addr (cur_tail),
    .wr_data (buf_q),
    .rd_addr (cur_head),
    .rd_data (link_rd)
  );

  // Descriptor arithmetic on the selected entry.
  assign {cur_head, cur_tail, cur_cnt} = rd_desc;

  always_comb begin
    nxt_head = cur_head;
    nxt_tail = cur_tail;
    nxt_cnt  = cur_cnt;
    link_we  = 1'b0;
    is_empty = 1'b0;
    out_buf  = buf_q;
    if (deq_q) begin
      out_buf = cur_head;
      if (cur_cnt == '0) begin
        is_empty = 1'b1;
      end else begin
        nxt_head = link_rd;
        nxt_cnt  = cur_cnt - 1'b1;
      end
    end else begin
      nxt_tail = buf_q;
      nxt_cnt  = cur_cnt + 1'b1;
      if (cur_cnt == '0)
        nxt_head = buf_q;
      else
        link_we = (state_q == ST_APPLY);
    end
  end

  assign new_desc  = {nxt_head, nxt_tail, nxt_cnt};
  assign wr_desc   = (state_q == ST_APPLY) ? new_desc : mem_rsp_rdata;
  assign last_slot = (slot_q == IW'(N_ENTRIES - 1));

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    deq_d   = deq_q;
    qid_d   = qid_q;
    buf_d   = buf_q;
    slot_d  = slot_q;
    hit_d   = hit_q;
    st_wr   = 1'b0;
    st_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (flush_req) begin
          state_d = ST_FL_REQ;
          slot_d  = '0;
        end else if (cmd_valid) begin
          state_d = ST_LOOK;
          hcnt_d  = HC_W'(HIT_CYCLES - 1);
          deq_d   = cmd_deq;
          qid_d   = cmd_qid;
          buf_d   = cmd_buf;
        end
      end
      ST_LOOK: begin
        if (hcnt_q != '0) begin
          hcnt_d = hcnt_q - 1'b1;
        end else begin
          hit_d = st_hit;
          if (st_hit) begin
            slot_d  = st_hit_idx;
            state_d = ST_APPLY;
          end else begin
            slot_d  = victim;
            state_d = st_valid[victim] ? ST_WB_REQ : ST_RD_REQ;
          end
        end
      end
      ST_WB_REQ:  state_d = ST_WB_WAIT;
      ST_WB_WAIT: if (mem_rsp_valid) state_d = ST_RD_REQ;
      ST_RD_REQ:  state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          st_wr   = 1'b1;
          state_d = ST_APPLY;
        end
      end
      ST_APPLY: begin
        st_wr   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FL_REQ: begin
        if (st_valid[slot_q]) begin
          state_d = ST_FL_WAIT;
        end else if (last_slot) begin
          st_clr  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      ST_FL_WAIT: begin
        if (mem_rsp_valid) begin
          if (last_slot) begin
            st_clr  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            slot_d  = slot_q + 1'b1;
            state_d = ST_FL_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      deq_q   <= 1'b0;
      qid_q   <= '0;
      buf_q   <= '0;
      slot_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      deq_q   <= deq_d;
      qid_q   <= qid_d;
      buf_q   <= buf_d;
      slot_q  <= slot_d;
      hit_q   <= hit_d;
    end
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_APPLY);
  assign rsp_hit       = hit_q;
  assign rsp_empty     = is_empty;
  assign rsp_buf       = out_buf;
  assign rsp_count     = nxt_cnt;

  assign mem_req_valid = (state_q == ST_WB_REQ) || (state_q == ST_RD_REQ) ||
                         ((state_q == ST_FL_REQ) && st_valid[slot_q]);
  assign mem_req_we    = (state_q != ST_RD_REQ);
  assign mem_req_qid   = (state_q == ST_RD_REQ) ? qid_q : rd_qid;
  assign mem_req_wdata = rd_desc;

endmodule

// File: rtl/qdc_checks.sv
module qdc_checks (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic flush_req,
  input logic rsp_valid,
  input logic rsp_empty,
  input logic rsp_count_zero,
  input logic mem_req_valid
);

  // R8: a response is only produced while busy
  a_r8_no_ready_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  // R8: the block returns to idle right after a response
  a_r8_idle_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (cmd_ready && !rsp_valid));

  // R7: an empty take reports zero length
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_empty) |-> rsp_count_zero);

  // R3: memory requests are single-cycle pulses
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R2: no memory traffic while idle
  a_r2_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);

  // R10: an accepted flush never produces a command response next
  a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && flush_req) |=> !rsp_valid);

endmodule

bind qdesc_cache qdc_checks u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_ready      (cmd_ready),
  .flush_req      (flush_req),
  .rsp_valid      (rsp_valid),
  .rsp_empty      (rsp_empty),
  .rsp_count_zero (rsp_count == '0),
  .mem_req_valid  (mem_req_valid)
);

// File: tb/qdesc_cache_bench.sv
module qdesc_cache_bench;

  localparam int N      = 4;
  localparam int QID_W  = 4;
  localparam int PTR_W  = 6;
  localparam int HIT    = 2;
  localparam int RATIO  = 4;
  localparam int L      = HIT * RATIO;
  localparam int CNT_W  = PTR_W + 1;
  localparam int DESC_W = 2 * PTR_W + CNT_W;
  localparam int NQ     = 1 << QID_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic cmd_valid, cmd_ready, cmd_deq, flush_req;
  logic [QID_W-1:0] cmd_qid;
  logic [PTR_W-1:0] cmd_buf;
  logic rsp_valid, rsp_hit, rsp_empty;
  logic [PTR_W-1:0] rsp_buf;
  logic [CNT_W-1:0] rsp_count;
  logic mem_req_valid, mem_req_we, mem_rsp_valid;
  logic [QID_W-1:0] mem_req_qid;
  logic [DESC_W-1:0] mem_req_wdata, mem_rsp_rdata;

  qdesc_cache #(.N_ENTRIES(N), .QID_W(QID_W), .PTR_W(PTR_W), .HIT_CYCLES(HIT)) u_qdesc_cache (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_deq(cmd_deq), .cmd_qid(cmd_qid), .cmd_buf(cmd_buf), .flush_req(flush_req),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_empty(rsp_empty),
    .rsp_buf(rsp_buf), .rsp_count(rsp_count), .mem_req_valid(mem_req_valid),
    .mem_req_we(mem_req_we), .mem_req_qid(mem_req_qid), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state
  int mq [NQ][$];
  int slot_m [N];
  int rec [$];
  int pool [$];
  logic [DESC_W-1:0] mem_desc [NQ];
  bit lg_we [$];
  int lg_qid [$];
  logic [DESC_W-1:0] lg_dat [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // External descriptor memory, fixed latency L
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && mem_req_valid === 1'b1) begin
        logic [DESC_W-1:0] rd;
        lg_we.push_back(mem_req_we);
        lg_qid.push_back(int'(mem_req_qid));
        lg_dat.push_back(mem_req_wdata);
        if (mem_req_we) mem_desc[mem_req_qid] = mem_req_wdata;
        rd = mem_desc[mem_req_qid];
        repeat (L) @(posedge clk);
        #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = rd;
        @(posedge clk);
        #1;
        mem_rsp_valid = 1'b0;
      end
    end
  end

  function automatic int find_slot(int q);
    for (int i = 0; i < N; i++) if (slot_m[i] == q) return i;
    return -1;
  endfunction

  function automatic int pick_victim();
    for (int i = 0; i < N; i++) if (slot_m[i] < 0) return i;
    return find_slot(rec[rec.size() - 1]);
  endfunction

  function automatic void touch(int q);
    for (int i = 0; i < rec.size(); i++)
      if (rec[i] == q) begin rec.delete(i); break; end
    rec.push_front(q);
  endfunction

  // R11: descriptor layout {head, tail, count}
  task automatic chk_desc(input logic [DESC_W-1:0] d, input int q);
    int c;
    c = mq[q].size();
    chk(int'(d[CNT_W-1:0]) == c, "R11", "written count", d[CNT_W-1:0], c);
    if (c > 0) begin
      chk(int'(d[DESC_W-1 -: PTR_W]) == mq[q][0], "R11", "written head",
          d[DESC_W-1 -: PTR_W], mq[q][0]);
      chk(int'(d[CNT_W +: PTR_W]) == mq[q][c-1], "R11", "written tail",
          d[CNT_W +: PTR_W], mq[q][c-1]);
    end
  endtask

  task automatic run_cmd(input bit deq, input int q, input string rq);
    int s, v, vq, e, ebuf, ecnt, k;
    bit ehit, eempty;
    s = find_slot(q);
    ehit = (s >= 0);
    v = ehit ? s : pick_victim();
    vq = ehit ? -1 : slot_m[v];
    e = ehit ? HIT + 1 : ((vq >= 0) ? HIT + 2*L + 3 : HIT + L + 2);
    ebuf = 0;
    eempty = 1'b0;
    if (deq) begin
      if (mq[q].size() == 0) begin eempty = 1'b1; ecnt = 0; end
      else begin ebuf = mq[q][0]; ecnt = mq[q].size() - 1; end
    end else begin
      ebuf = pool.pop_front();
      ecnt = mq[q].size() + 1;
    end
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R8", "ready when idle", cmd_ready, 1);
    lg_we.delete(); lg_qid.delete(); lg_dat.delete();
    cmd_valid = 1'b1;
    cmd_deq   = deq;
    cmd_qid   = QID_W'(q);
    cmd_buf   = PTR_W'(ebuf);
    for (int c = 1; c <= e; c++) begin
      @(negedge clk);
      if (c == 1) cmd_valid = 1'b0;
      chk(rsp_valid === (c == e), rq, "response cycle", rsp_valid, (c == e));
      chk(cmd_ready === 1'b0, "R8", "busy ready low", cmd_ready, 0);
      if (c == e) begin
        chk(rsp_hit === ehit, ehit ? "R2" : "R3", "hit flag", rsp_hit, ehit);
        chk(rsp_empty === eempty, "R7", "empty flag", rsp_empty, eempty);
        chk(int'(rsp_count) == ecnt, "R6", "count", rsp_count, ecnt);
        if (!eempty) chk(int'(rsp_buf) == ebuf, "R6", "buffer", rsp_buf, ebuf);
      end
    end
    // memory traffic of this command
    k = 0;
    if (!ehit && vq >= 0) begin
      chk(lg_we.size() == 2, "R4", "request count on eviction", lg_we.size(), 2);
      if (lg_we.size() >= 1) begin
        chk(lg_we[0] == 1'b1, "R4", "writeback first", lg_we[0], 1);
        chk(lg_qid[0] == vq, "R5", "victim queue", lg_qid[0], vq);
        chk_desc(lg_dat[0], vq);
      end
      k = 1;
    end else begin
      chk(lg_we.size() == (ehit ? 0 : 1), ehit ? "R2" : "R3", "request count",
          lg_we.size(), ehit ? 0 : 1);
    end
    if (!ehit && lg_we.size() > k) begin
      chk(lg_we[k] == 1'b0, "R3", "read request", lg_we[k], 0);
      chk(lg_qid[k] == q, "R3", "read queue", lg_qid[k], q);
    end
    // update reference
    if (!ehit) begin
      if (vq >= 0)
        for (int i = 0; i < rec.size(); i++)
          if (rec[i] == vq) begin rec.delete(i); break; end
      slot_m[v] = q;
    end
    touch(q);
    if (deq) begin
      if (!eempty) begin void'(mq[q].pop_front()); pool.push_back(ebuf); end
    end else begin
      mq[q].push_back(ebuf);
    end
  endtask

  task automatic flush_all(input bit with_cmd);
    int nv, d, k;
    nv = 0;
    for (int i = 0; i < N; i++) if (slot_m[i] >= 0) nv++;
    d = N + nv * L;
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R9", "ready before flush", cmd_ready, 1);
    lg_we.delete(); lg_qid.delete(); lg_dat.delete();
    flush_req = 1'b1;
    if (with_cmd) begin
      cmd_valid = 1'b1; cmd_deq = 1'b0; cmd_qid = QID_W'(1); cmd_buf = '0;
    end
    for (int c = 1; c <= d + 1; c++) begin
      @(negedge clk);
      if (c == 1) begin flush_req = 1'b0; cmd_valid = 1'b0; end
      chk(rsp_valid === 1'b0, "R10", "no response in flush", rsp_valid, 0);
      chk(cmd_ready === (c == d + 1), "R9", "flush duration", cmd_ready, (c == d + 1));
    end
    k = 0;
    for (int i = 0; i < N; i++) begin
      if (slot_m[i] >= 0) begin
        if (lg_we.size() > k) begin
          chk(lg_we[k] == 1'b1, "R9", "flush writes", lg_we[k], 1);
          chk(lg_qid[k] == slot_m[i], "R9", "flush order", lg_qid[k], slot_m[i]);
          chk_desc(lg_dat[k], slot_m[i]);
        end
        k++;
      end
    end
    chk(lg_we.size() == k, "R9", "flush request count", lg_we.size(), k);
    for (int i = 0; i < N; i++) slot_m[i] = -1;
    rec.delete();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog: actual %0d cycles expected completion", 60000);
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_deq = 1'b0; cmd_qid = '0; cmd_buf = '0; flush_req = 1'b0;
    for (int i = 0; i < NQ; i++) mem_desc[i] = '0;
    for (int i = 0; i < N; i++) slot_m[i] = -1;
    for (int i = 0; i < (1 << PTR_W); i++) pool.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready === 1'b1, "R1", "ready after reset", cmd_ready, 1);
    chk(rsp_valid === 1'b0, "R1", "no response after reset", rsp_valid, 0);
    chk(mem_req_valid === 1'b0, "R1", "no request after reset", mem_req_valid, 0);

    run_cmd(1'b0, 3, "R1");   // first command: miss, read only
    run_cmd(1'b0, 3, "R2");
    run_cmd(1'b0, 3, "R2");
    run_cmd(1'b1, 3, "R6");
    run_cmd(1'b1, 5, "R7");   // empty take on a fetched queue
    run_cmd(1'b0, 7, "R3");
    run_cmd(1'b0, 9, "R3");
    run_cmd(1'b0, 11, "R4");  // full: evicts queue 3 holding two buffers
    run_cmd(1'b1, 5, "R7");   // empty take refreshes queue 5
    run_cmd(1'b0, 12, "R5");  // victim must be queue 7
    run_cmd(1'b1, 3, "R6");   // refetch of evicted queue 3
    flush_all(1'b1);          // R10: command offered with the flush
    run_cmd(1'b0, 3, "R9");   // after flush: miss without writeback

    seed = 32'h1234_5678;
    for (int n = 0; n < 80; n++) begin
      bit deq;
      int q;
      seed = seed * 32'd1103515245 + 32'd12345;
      q = int'((seed >> 8) % 8);
      deq = seed[20] & seed[21];
      if (!deq && pool.size() == 0) deq = 1'b1;
      run_cmd(deq, q, "R6");
    end
    flush_all(1'b0);
    for (int q = 0; q < NQ; q++) begin
      chk(int'(mem_desc[q][CNT_W-1:0]) == mq[q].size(), "R11", "memory count after flush",
          mem_desc[q][CNT_W-1:0], mq[q].size());
      if (mq[q].size() > 0)
        chk(int'(mem_desc[q][DESC_W-1 -: PTR_W]) == mq[q][0], "R11", "memory head after flush",
            mem_desc[q][DESC_W-1 -: PTR_W], mq[q][0]);
    end
    summary();
    $finish;
  end

endmodule